// File: doc/BRIEF.md
# Greyscale Framebuffer Scanout to RGB565

This block walks a packed greyscale display memory once per trigger and turns it into a raster stream of 16-bit colour pixels. The visible area is 128 pixels across and 64 lines down. Each memory byte holds two neighbouring pixels of 4 bits each, so one line takes 64 bytes. Line y of the image always comes from line y of the memory. No remapping, offset or start-line shift is applied.

A pulse on `frame_go` while the block is idle starts one frame. The block then issues byte reads in ascending address order to a memory that returns data one cycle after the read strobe. It splits each byte into a left pixel and a right pixel and expands each 4-bit level to an RGB565 word. The pixels are handed downstream with a valid/ready handshake, plus markers for the first pixel of a line and of the frame. A one-cycle `frame_done` pulse closes the frame. Throughput is one pixel per cycle while the consumer is ready. When ready is low, the stream holds its current pixel.

Top module: `grey_scan565`

## Requirements
- R1: After reset, `px_valid`, `px_sol`, `px_sof`, `rd_en` and `frame_done` are low, and they stay low until `frame_go` is seen.
- R2: A `frame_go` pulse while idle produces exactly 8192 accepted pixels, followed by one `frame_done` pulse. Nothing further is emitted until the next `frame_go`.
- R3: Byte k of the frame is requested with `rd_en` high and `rd_addr` = k, for k = 0 to 4095 in ascending order, once each. Byte k belongs to line k/64, so memory line y feeds picture line y. `rd_byte` is taken in the cycle right after the strobe.
- R4: Picture pixel 2k is bits 7:4 of byte k and pixel 2k+1 is bits 3:0, so the upper nibble is the left pixel.
- R5: For grey level g, let n = 2g + (g >> 3), a 5-bit value. `px_rgb[15:8]` = ((n << 3) | (n >> 2)) mod 256 and `px_rgb[7:0]` = (n | (n << 6) | ((n << 1) & 0x20)) mod 256. Level 15 gives 0xFFFF and level 0 gives 0x0000.
- R6: `px_sol` is high with the first pixel of every line (pixel index a multiple of 128) and low otherwise.
- R7: `px_sof` is high only with pixel 0 of the frame.
- R8: `frame_done` is high for exactly one cycle, the cycle after the last pixel is accepted.
- R9: While `px_valid` is high and `px_ready` is low, the next cycle keeps `px_valid`, `px_rgb`, `px_sol` and `px_sof` unchanged.
- R10: With `px_ready` held high, `px_valid` has no gap between the first and the last pixel of a frame.
- R11: `frame_go` during a frame has no effect: the stream, the reads and the single `frame_done` are the same as without it, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | Starts one frame when idle |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 12 | Byte address of the read |
| rd_byte | input | 8 | Read data, valid the cycle after `rd_en` |
| px_ready | input | 1 | Downstream can take a pixel |
| px_valid | output | 1 | Pixel on `px_rgb` is valid |
| px_rgb | output | 16 | RGB565 pixel |
| px_sol | output | 1 | First pixel of a line |
| px_sof | output | 1 | First pixel of the frame |
| frame_done | output | 1 | One-cycle pulse after the final pixel |

## Verification
Frames are scanned over random memory images whose first bytes are set so that every grey level turns up in both the upper and lower nibble. A swapped nibble, a wrong expansion bit or a misread address therefore changes a compared pixel. One frame runs with the consumer always ready, which exposes pipeline bubbles and an off-by-one in the done timing. A second frame randomly drops ready half the time and pulses the trigger mid-frame, which separates correct holding from lost or duplicated pixels and shows that the stray trigger is ignored. A third frame is mostly stalled, so the read and refill paths are exercised while the two staging bytes are both occupied. The memory model returns garbage whenever no read was issued the cycle before, so sampling the read data in the wrong cycle shows up as pixel mismatches.

// File: rtl/grey_scan565.sv
module grey_scan565 #(
  parameter int H_PIX = 128,
  parameter int V_LINES = 64,
  localparam int BPL = H_PIX / 2,
  localparam int NBYTES = BPL * V_LINES,
  localparam int AW = $clog2(NBYTES),
  localparam int CW = $clog2(BPL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_go,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_byte,
  input  logic          px_ready,
  output logic          px_valid,
  output logic [15:0]   px_rgb,
  output logic          px_sol,
  output logic          px_sof,
  output logic          frame_done
);
  localparam logic [AW-1:0] LAST = AW'(NBYTES - 1);

  logic          run, rd_all, pend, done_q;
  logic          nxt_full, cur_full, lo_half;
  logic [7:0]    nxt_byte, cur_byte;
  logic [AW-1:0] rd_idx, out_idx;
  logic          fire, take, issue;
  logic [3:0]    grey;
  logic [4:0]    lvl;

  assign fire  = cur_full && px_ready;
  assign take  = nxt_full && (!cur_full || (lo_half && fire));
  assign issue = run && !rd_all && !pend && (!nxt_full || take);

  assign grey = lo_half ? cur_byte[3:0] : cur_byte[7:4];
  assign lvl  = {grey, grey[3]};

  assign px_rgb     = {lvl, lvl, lvl[4], lvl};
  assign px_valid   = cur_full;
  assign px_sol     = cur_full && !lo_half && (out_idx[CW-1:0] == '0);
  assign px_sof     = px_sol && (out_idx[AW-1:CW] == '0);
  assign rd_en      = issue;
  assign rd_addr    = rd_idx;
  assign frame_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      rd_all   <= 1'b0;
      pend     <= 1'b0;
      done_q   <= 1'b0;
      nxt_full <= 1'b0;
      cur_full <= 1'b0;
      lo_half  <= 1'b0;
      nxt_byte <= '0;
      cur_byte <= '0;
      rd_idx   <= '0;
      out_idx  <= '0;
    end else begin
      done_q <= 1'b0;
      pend   <= issue;

      if (!run && frame_go) begin
        run     <= 1'b1;
        rd_all  <= 1'b0;
        rd_idx  <= '0;
        out_idx <= '0;
      end

      if (issue) begin
        rd_idx <= rd_idx + 1'b1;
        if (rd_idx == LAST) rd_all <= 1'b1;
      end

      if (pend) begin
        nxt_byte <= rd_byte;
        nxt_full <= 1'b1;
      end else if (take) begin
        nxt_full <= 1'b0;
      end

      if (take) begin
        cur_byte <= nxt_byte;
        cur_full <= 1'b1;
        lo_half  <= 1'b0;
      end else if (fire) begin
        if (lo_half) cur_full <= 1'b0;
        else         lo_half  <= 1'b1;
      end

      if (fire && lo_half) begin
        out_idx <= out_idx + 1'b1;
        if (out_idx == LAST) begin
          run    <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/grey_scan565_chk.sv
module grey_scan565_chk #(
  parameter int H_PIX = 128,
  parameter int V_LINES = 64,
  localparam int BPL = H_PIX / 2,
  localparam int NBYTES = BPL * V_LINES,
  localparam int AW = $clog2(NBYTES),
  localparam int CW = $clog2(BPL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          px_ready,
  input logic          px_valid,
  input logic [15:0]   px_rgb,
  input logic          px_sol,
  input logic          px_sof,
  input logic          frame_done
);
  logic [AW-1:0] rd_cnt;
  logic [AW:0]   pix_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt  <= '0;
      pix_cnt <= '0;
    end else begin
      if (rd_en) rd_cnt <= rd_cnt + 1'b1;
      if (px_valid && px_ready) pix_cnt <= pix_cnt + 1'b1;
    end
  end

  a_r3_addr_order: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr == rd_cnt);

  a_r3_rd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  a_r6_sol_column: assert property (@(posedge clk) disable iff (!rst_n)
    px_sol |-> px_valid && (pix_cnt[CW:0] == '0));

  a_r7_sof_first: assert property (@(posedge clk) disable iff (!rst_n)
    px_sof |-> px_sol && (pix_cnt == '0));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r2_done_count: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (pix_cnt == '0) && !px_valid);

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && !px_ready |=> px_valid && $stable(px_rgb) && $stable(px_sol) && $stable(px_sof));
endmodule

bind grey_scan565 grey_scan565_chk #(.H_PIX(H_PIX), .V_LINES(V_LINES)) u_chk (.*);

// File: tb/sim_grey_scan565.sv
`timescale 1ns/1ps
module sim_grey_scan565;
  localparam int H = 128;
  localparam int V = 64;
  localparam int NB = H / 2 * V;
  localparam int AW = $clog2(NB);
  localparam int NPIX = 2 * NB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_go = 1'b0;
  logic          px_ready = 1'b0;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_byte = 8'h00;
  logic          px_valid, px_sol, px_sof, frame_done;
  logic [15:0]   px_rgb;
  logic [7:0]    mem [NB];
  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  always_ff @(posedge clk)
    rd_byte <= rd_en ? mem[rd_addr] : (~rd_byte ^ 8'h3C);

  grey_scan565 u0 (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_byte(rd_byte),
    .px_ready(px_ready), .px_valid(px_valid), .px_rgb(px_rgb),
    .px_sol(px_sol), .px_sof(px_sof), .frame_done(frame_done)
  );

  function automatic logic [15:0] exp_rgb(int g);
    int n, lo, hi;
    n  = 2 * g + (g >> 3);
    lo = (n | (n << 6) | ((n << 1) & 32)) & 255;
    hi = ((n << 3) | (n >> 2)) & 255;
    return 16'(hi * 256 + lo);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < NB; i++) mem[i] = 8'($urandom);
    mem[0] = 8'hF0;
    for (int i = 0; i < 16; i++) mem[i + 1] = {4'(i), ~4'(i)};
  endtask

  function automatic logic pick_ready(int mode);
    if (mode == 0) return 1'b1;
    if (mode == 1) return 1'($urandom % 2);
    return ($urandom % 4) == 0;
  endfunction

  task automatic run_frame(int mode, int stray_at);
    int p = 0;
    int reads = 0;
    logic last_seen = 1'b0;
    logic done_seen = 1'b0;
    logic prv_stall = 1'b0;
    logic [18:0] prv = '0;
    logic [7:0] b;
    logic [3:0] g;
    @(negedge clk);
    frame_go = 1'b1;
    px_ready = pick_ready(mode);
    while (!done_seen) begin
      @(negedge clk);
      frame_go = (stray_at > 0 && p == stray_at);  // R11 stray trigger
      px_ready = pick_ready(mode);
      #1;
      if (rd_en) begin
        chk("R3 read address", 32'(rd_addr), 32'(reads));
        reads++;
      end
      if (prv_stall)
        chk("R9 held pixel", {13'd0, px_valid, px_sol, px_sof, px_rgb}, {13'd0, prv});
      chk("R8 done timing", 32'(frame_done), 32'(last_seen));
      if (frame_done) done_seen = 1'b1;
      last_seen = 1'b0;
      if (mode == 0 && p > 0 && p < NPIX)
        chk("R10 no bubble", 32'(px_valid), 32'd1);
      if (px_valid && px_ready) begin
        b = mem[p >> 1];
        g = p[0] ? b[3:0] : b[7:4];  // R4 nibble order
        chk("R4/R5 pixel colour", 32'(px_rgb), 32'(exp_rgb(int'(g))));
        chk("R6 line start", 32'(px_sol), 32'((p % H) == 0));
        chk("R7 frame start", 32'(px_sof), 32'(p == 0));
        if (p == NPIX - 1) last_seen = 1'b1;
        p++;
      end
      prv_stall = px_valid && !px_ready;
      prv = {px_valid, px_sol, px_sof, px_rgb};
    end
    frame_go = 1'b0;
    chk("R2 pixel count", 32'(p), 32'(NPIX));
    chk("R3 read count", 32'(reads), 32'(NB));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      px_ready = 1'($urandom % 2);
      #1;
      chk("R11 idle after frame", {29'd0, px_valid, rd_en, frame_done}, 32'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fill_mem();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      px_ready = 1'($urandom % 2);
      #1;
      chk("R1 reset/idle state", {27'd0, px_valid, px_sol, px_sof, rd_en, frame_done}, 32'd0);
    end
    chk("R5 level 15 word", 32'(exp_rgb(15)), 32'hFFFF);
    run_frame(0, 0);
    fill_mem();
    run_frame(1, 3000);
    fill_mem();
    run_frame(2, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected frame completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule